// File: doc/BRIEF.md
# Bubble-Collapsing Elastic Pipeline

This block is a chain of identical storage stages that carries data words from an upstream producer to a downstream consumer. Both sides use a valid/ready handshake. The producer may leave gaps between words. The consumer may refuse words for any number of cycles. Each stage holds one word and a flag that marks whether the word is real.

Every stage applies the same local rule to decide whether to take the contents of its left neighbour. A stage loads when the consumer is ready, or when it or any stage closer to the output is empty. Gaps therefore close up while the output is stalled, so they never reach the consumer. The full depth of the chain stays usable as buffering whatever the input pattern. When the chain is full and the consumer is stalled, nothing moves and the producer is held off.

Top module: `bubble_squeeze_pipe`

## Requirements
- R1: A synchronous active-high reset clears every stage flag. After reset `outValid` is 0 and `inReady` is 1.
- R2: Words leave in the order they were accepted, with none lost or duplicated, under any mix of input gaps and output stalls. A word is accepted on a rising edge where `inValid` and `inReady` are both 1. It is delivered on a rising edge where `outValid` and `outReady` are both 1.
- R3: While the chain holds `STAGES` words and `outReady` is 0, no word moves: `inReady` is 0 and `outData` does not change.
- R4: Once `outValid` is 1 with `outReady` at 0, the next cycle still shows `outValid` at 1 with the same `outData`.
- R5: While `outReady` is held at 0, gaps in the input are squeezed out. The chain accepts exactly `STAGES` words before it deasserts `inReady`.
- R6: `inReady` is 1 exactly when `outReady` is 1 or fewer than `STAGES` words are stored.
- R7: A word accepted into an empty chain with `outReady` held at 1 first shows on `outValid` `STAGES` rising edges after acceptance, counting the accepting edge.
- R8: With `inValid` and `outReady` held at 1, the chain accepts and delivers one word every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Producer offers a word |
| inData | input | DATA_W | Offered word |
| inReady | output | 1 | Chain takes the offered word this cycle |
| outValid | output | 1 | Last stage holds a word |
| outData | output | DATA_W | Word in the last stage |
| outReady | input | 1 | Consumer takes the presented word |

## Verification
In one cycle the chain can both accept a word at its input and give one up at its output. In the same cycle, a stage in the middle can be filled from the left while stages further right are squeezing a gap. The bench provokes this by driving `inValid` and `outReady` at random with partial probability for a long run. It compares every delivered word with a scoreboard queue fed at acceptance, and each cycle it checks `inReady` against a model of occupancy. A cycle in which acceptance and delivery coincide wrongly shows up as a lost, repeated or misordered word, or as an occupancy mismatch.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  // Per-stage strobes handed from control to datapath.
  typedef struct packed {
    logic shift;     // stage loads from its left neighbour this cycle
    logic srcValid;  // the word it would load is a real word
  } stageCtl_t;
endpackage

// File: rtl/pipe_ctl.sv
module pipe_ctl
  import pipe_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic                     outReady,
  output logic                     inReady,
  output logic                     outValid,
  output stageCtl_t [STAGES-1:0]   ctl
);
  localparam int CNT_W = $clog2(STAGES + 1);

  logic [STAGES-1:0] validQ;
  // holeAt[i]: consumer ready, or some stage at index >= i is empty
  logic [STAGES:0]   holeAt;

  assign holeAt[STAGES] = outReady;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic srcV;
    if (i == 0) begin : g_head
      assign srcV = inValid;
    end else begin : g_body
      assign srcV = validQ[i-1];
    end

    assign holeAt[i]       = ~validQ[i] | holeAt[i+1];
    assign ctl[i].shift    = holeAt[i];
    assign ctl[i].srcValid = srcV;

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ[i] <= 1'b0;
      end else if (holeAt[i]) begin
        validQ[i] <= srcV;
      end
    end
  end

  assign inReady  = holeAt[0];
  assign outValid = validQ[STAGES-1];

  logic [CNT_W-1:0] fillCnt;
  assign fillCnt = CNT_W'($countones(validQ));

  // R1: reset empties the chain
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (validQ == '0));

  // R2: occupancy changes only by accepted and delivered words
  p_conserve_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(validQ) ==
              $countones($past(validQ)) + int'($past(inValid && inReady))
              - int'($past(outValid && outReady))));

  // R6: a chain with room always accepts
  p_room_accepts_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(fillCnt) < STAGES) |-> inReady);
endmodule

// File: rtl/pipe_dp.sv
module pipe_dp
  import pipe_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int DATA_W = 200
) (
  input  logic                     clk,
  input  stageCtl_t [STAGES-1:0]   ctl,
  input  logic [DATA_W-1:0]        inData,
  output logic [DATA_W-1:0]        outData
);
  logic [DATA_W-1:0] stageQ [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [DATA_W-1:0] srcD;
    if (i == 0) begin : g_head
      assign srcD = inData;
    end else begin : g_body
      assign srcD = stageQ[i-1];
    end

    // Data registers carry no reset; they load only real words.
    always_ff @(posedge clk) begin
      if (ctl[i].shift && ctl[i].srcValid) begin
        stageQ[i] <= srcD;
      end
    end
  end

  assign outData = stageQ[STAGES-1];
endmodule

// File: rtl/bubble_squeeze_pipe.sv
module bubble_squeeze_pipe
  import pipe_pkg::*;
#(
  parameter int STAGES = 16,
  parameter int DATA_W = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);
  stageCtl_t [STAGES-1:0] ctl;

  pipe_ctl #(.STAGES(STAGES)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  pipe_dp #(.STAGES(STAGES), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .ctl     (ctl),
    .inData  (inData),
    .outData (outData)
  );

  // R4: a refused word stays put
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

// File: tb/tb_bubble_squeeze_pipe.sv
module tb_bubble_squeeze_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int DW = 200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [DW-1:0] inData = '0;
  logic          inReady;
  logic          outValid;
  logic [DW-1:0] outData;
  logic          outReady = 1'b0;

  int checks = 0;
  int fails  = 0;
  int occ    = 0;
  int seq    = 0;
  logic [DW-1:0] sb [$];
  bit            prevHold = 1'b0;
  logic [DW-1:0] prevData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bubble_squeeze_pipe #(.STAGES(N), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .outReady(outReady)
  );

  function automatic logic [DW-1:0] mkWord(int k);
    logic [DW-1:0] w = '0;
    for (int c = 0; c < (DW + 31) / 32; c++) begin
      w = w | (DW'(32'(k) * 32'h9E3779B1 ^ 32'(c) * 32'h85EBCA6B) << (c * 32));
    end
    return w;
  endfunction

  task automatic chk(bit ok, string req, string act, string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and records accepted words.
  task automatic drive(bit v, bit r);
    @(negedge clk);
    inValid  = v;
    inData   = mkWord(seq);
    outReady = r;
    #1;
    chk(inReady === (r || occ < N), "R6 inReady",
        $sformatf("%b", inReady), $sformatf("%b", (r || occ < N)));
    if (v && inReady) begin
      sb.push_back(inData);
      seq++;
      occ++;
    end
  endtask

  // Monitor: compares delivered words against the scoreboard.
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (prevHold) begin
        chk(outValid === 1'b1 && outData === prevData, "R4 hold",
            $sformatf("%b/%h", outValid, outData), $sformatf("1/%h", prevData));
      end
      if (outValid && outReady) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2 extra word", $sformatf("%h", outData), "none");
        end else begin
          logic [DW-1:0] e;
          e = sb.pop_front();
          chk(outData === e, "R2 order", $sformatf("%h", outData), $sformatf("%h", e));
          occ--;
        end
      end
      prevHold = outValid && !outReady;
      prevData = outData;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    int cnt;
    int gaps;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(outValid === 1'b0, "R1 outValid", $sformatf("%b", outValid), "0");
    chk(inReady === 1'b1, "R1 inReady", $sformatf("%b", inReady), "1");

    // R7: latency through an empty chain
    drive(1, 1);
    cnt = 0;
    for (int k = 0; k < 4 * N; k++) begin
      drive(0, 1);
      #1;
      cnt++;
      if (outValid) break;
    end
    chk(cnt == N, "R7 latency", $sformatf("%0d", cnt), $sformatf("%0d", N));
    repeat (3) drive(0, 1);

    // R8: full-rate streaming
    for (int k = 0; k < 40; k++) begin
      drive(1, 1);
      chk(inReady === 1'b1, "R8 stream", $sformatf("%b", inReady), "1");
    end
    repeat (N + 4) drive(0, 1);
    chk(occ == 0 && sb.size() == 0, "R2 drained", $sformatf("%0d", occ), "0");

    // R5: stalled output, gappy input fills every stage
    gaps = 0;
    for (int k = 0; k < 200 && occ < N; k++) begin
      drive(k % 3 == 0, 0);
      gaps++;
    end
    chk(occ == N, "R5 capacity", $sformatf("%0d", occ), $sformatf("%0d", N));
    drive(1, 0);
    chk(inReady === 1'b0, "R5 full", $sformatf("%b", inReady), "0");

    // R3: full and stalled, nothing moves
    held = outData;
    for (int k = 0; k < 6; k++) begin
      drive(1, 0);
      chk(inReady === 1'b0 && outData === held, "R3 frozen",
          $sformatf("%b/%h", inReady, outData), $sformatf("0/%h", held));
    end
    repeat (N + 4) drive(0, 1);

    // R2/R6: random gaps and stalls, accept and deliver collide
    for (int k = 0; k < 3000; k++) begin
      drive(($urandom % 100) < 60, ($urandom % 100) < 55);
    end
    repeat (2 * N + 8) drive(0, 1);
    chk(sb.size() == 0 && outValid === 1'b0, "R2 final drain",
        $sformatf("%0d", sb.size()), "0");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule